// File: doc/BRIEF.md
# Oversampled Serial Receiver with Flag-Tagged Receive Queue

This block turns an asynchronous serial input line into parallel characters. It oversamples the line with a tick that runs at sixteen times the bit rate and takes each bit at the middle of its tick window. It accepts 5 to 8 data bits, optional odd or even parity and one or two stop bits. Each finished character goes into a receive queue together with four status flags: break, overrun, parity error and framing error. A reader sees the character and its flags in one 12-bit word and removes it with a one-cycle pop strobe.

The host logic drives the frame format and the rate divisor, and the block decodes no registers itself. The block has three outputs for the host. A queue-empty status shows when nothing is waiting. A fill-level interrupt asks for a batch read. A timeout interrupt reports characters that are left in the queue after the line has gone quiet.

Top module: `rx_serial_core`

## Requirements
- R1: The oversampling tick runs once every (divisor_i + 1) clocks, so one bit lasts 16 × (divisor_i + 1) clocks. A start bit is confirmed half a bit after the falling edge, and each later bit is sampled 16 ticks after the previous one.
- R2: wlen_i codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The bits arrive LSB first, and the unused upper character bits read as 0.
- R3: With par_en_i = 1, a parity bit follows the data. par_even_i = 1 expects an even count of ones over data plus parity, and 0 expects an odd count. A mismatch sets bit 9 of the entry.
- R4: A low stop bit sets bit 8 (framing) of the entry. With stop2_i = 1, both stop bits are checked. After a low stop bit, the receiver waits for the line to return high before it looks for a new start.
- R5: If the line is low for every sample of a frame, start and stop bits included, the entry has bit 11 (break) set, bits 9 and 8 clear and a character of 0. One entry is stored per break.
- R6: With fifo_en_i = 1, the queue holds up to DEPTH (16) entries and returns them in arrival order.
- R7: If a character completes while the queue is full and no pop happens in the same cycle, that character is dropped and bit 10 (overrun) is set on the newest stored entry.
- R8: With fifo_en_i = 0, the queue holds a single entry.
- R9: rx_empty_o is 1 exactly when the queue holds no entry. While it is empty, rd_data_o reads 0 and a pop has no effect.
- R10: rx_irq_o is 1 while the queue holds at least DEPTH/2 entries (fifo_en_i = 1), or at least one entry (fifo_en_i = 0).
- R11: rx_tmo_irq_o is 1 once the queue has been non-empty for 32 bit times with no start bit confirmed and no pop. A start bit, a pop or an empty queue restarts the count.
- R12: A low pulse shorter than half a bit is rejected as noise and stores nothing.
- R13: After reset the queue is empty, both interrupts are low and rd_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial input line, idle high |
| divisor_i | input | DIV_W | Rate divisor; tick every divisor_i+1 clocks |
| wlen_i | input | 2 | Data bits minus 5 |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| stop2_i | input | 1 | Two stop bits |
| fifo_en_i | input | 1 | 1 = DEPTH-entry queue, 0 = single entry |
| pop_i | input | 1 | Remove the head entry |
| rd_data_o | output | 12 | {break, overrun, parity, framing, char[7:0]} of the head entry |
| rx_empty_o | output | 1 | Queue empty |
| rx_irq_o | output | 1 | Fill-level interrupt |
| rx_tmo_irq_o | output | 1 | Idle-timeout interrupt |

## Verification
The bench targets the frame tail. It sends a low first or second stop bit, which a design that checked only one stop bit would accept silently. It also holds a break across a parity frame, which a design that did not mask the flags would report as break with parity and framing errors. The bench fills the queue past its depth to confirm that the seventeenth character is dropped and that the overrun lands on entry sixteen, not on a new entry or the head. It also repeats this in single-entry mode. Further cases cover a short noise pulse, a non-zero divisor and the timeout window sampled on both sides of 32 bit times. A miscounted divisor or a sample point shifted off mid-bit garbles the characters, and an off-by-one window fires the timeout early or never.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int unsigned OS_RATE = 16;

  typedef struct packed {
    logic       brk;
    logic       ovr;
    logic       par;
    logic       frm;
    logic [7:0] ch;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_HOLD
  } rx_state_e;
endpackage

// File: rtl/rxs_tick_gen.sv
module rxs_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rxs_frame.sv
module rxs_frame
  import rxs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      rxd_i,
  input  logic [1:0] wlen_i,
  input  logic      par_en_i,
  input  logic      par_even_i,
  input  logic      stop2_i,
  output logic      valid_o,
  output rx_entry_t entry_o,
  output logic      start_o
);
  localparam int unsigned CW = $clog2(OS_RATE);
  localparam logic [CW-1:0] MID  = CW'(OS_RATE/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OS_RATE - 1);

  logic      sync1_q, rx_q;
  rx_state_e st_q;
  logic [CW-1:0] os_q;
  logic [2:0] idx_q;
  logic [7:0] data_q;
  logic       perr_q, ferr_q, low_q;
  logic [2:0] last_idx;
  logic       fin_low, fin_frm;

  assign last_idx = 3'(wlen_i) + 3'd4;
  assign fin_low  = low_q & ~rx_q;
  assign fin_frm  = ferr_q | ~rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      rx_q    <= 1'b1;
    end else begin
      sync1_q <= rxd_i;
      rx_q    <= sync1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      os_q    <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      low_q   <= 1'b0;
      valid_o <= 1'b0;
      start_o <= 1'b0;
      entry_o <= '0;
    end else begin
      valid_o <= 1'b0;
      start_o <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          S_IDLE: if (!rx_q) begin
            st_q <= S_START;
            os_q <= '0;
          end
          S_START: begin
            if (os_q == MID) begin
              os_q <= '0;
              if (!rx_q) begin
                st_q    <= S_DATA;
                idx_q   <= '0;
                data_q  <= '0;
                perr_q  <= 1'b0;
                ferr_q  <= 1'b0;
                low_q   <= 1'b1;
                start_o <= 1'b1;
              end else begin
                st_q <= S_IDLE;
              end
            end else os_q <= os_q + 1'b1;
          end
          S_DATA: begin
            if (os_q == LAST) begin
              os_q          <= '0;
              data_q[idx_q] <= rx_q;
              low_q         <= low_q & ~rx_q;
              if (idx_q == last_idx) st_q <= par_en_i ? S_PAR : S_STOP1;
              else                   idx_q <= idx_q + 1'b1;
            end else os_q <= os_q + 1'b1;
          end
          S_PAR: begin
            if (os_q == LAST) begin
              os_q   <= '0;
              perr_q <= (^data_q) ^ rx_q ^ ~par_even_i;
              low_q  <= low_q & ~rx_q;
              st_q   <= S_STOP1;
            end else os_q <= os_q + 1'b1;
          end
          S_STOP1, S_STOP2: begin
            if (os_q == LAST) begin
              os_q <= '0;
              if (st_q == S_STOP1 && stop2_i) begin
                ferr_q <= ~rx_q;
                low_q  <= fin_low;
                st_q   <= S_STOP2;
              end else begin
                valid_o       <= 1'b1;
                entry_o.ch    <= data_q;
                entry_o.ovr   <= 1'b0;
                entry_o.brk   <= fin_low;
                entry_o.par   <= perr_q & ~fin_low;
                entry_o.frm   <= fin_frm & ~fin_low;
                st_q          <= rx_q ? S_IDLE : S_HOLD;
              end
            end else os_q <= os_q + 1'b1;
          end
          S_HOLD: if (rx_q) st_q <= S_IDLE;
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo
  import rxs_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          push_i,
  input  rx_entry_t     push_data_i,
  input  logic          pop_i,
  output rx_entry_t     data_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  rx_entry_t mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cap;
  logic full, do_pop, do_push, mark_ovr;

  assign cap      = en_i ? CW'(DEPTH) : CW'(1);
  assign full     = (count_o >= cap);
  assign empty_o  = (count_o == '0);
  assign do_pop   = pop_i & ~empty_o;
  assign do_push  = push_i & (~full | do_pop);
  assign mark_ovr = push_i & full & ~do_pop;
  assign data_o   = empty_o ? '0 : mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push)       mem_q[wr_q] <= push_data_i;
    else if (mark_ovr) mem_q[wr_q - 1'b1].ovr <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      count_o <= count_o + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/rxs_timeout.sv
module rxs_timeout #(
  parameter int unsigned LIMIT = 512,
  localparam int unsigned TW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  output logic tmo_o
);
  logic [TW-1:0] cnt_q;

  assign tmo_o = (cnt_q == TW'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (tick_i && !tmo_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rx_serial_core.sv
module rx_serial_core
  import rxs_pkg::*;
#(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned TMO_BITS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rxd_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic [1:0]       wlen_i,
  input  logic             par_en_i,
  input  logic             par_even_i,
  input  logic             stop2_i,
  input  logic             fifo_en_i,
  input  logic             pop_i,
  output logic [11:0]      rd_data_o,
  output logic             rx_empty_o,
  output logic             rx_irq_o,
  output logic             rx_tmo_irq_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          tick, frm_valid, frm_start;
  rx_entry_t     frm_entry, head;
  logic [CW-1:0] fifo_cnt;

  rxs_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .div_i(divisor_i), .tick_o(tick)
  );

  rxs_frame u_frame (
    .clk_i, .rst_ni, .tick_i(tick), .rxd_i,
    .wlen_i, .par_en_i, .par_even_i, .stop2_i,
    .valid_o(frm_valid), .entry_o(frm_entry), .start_o(frm_start)
  );

  rxs_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .en_i(fifo_en_i),
    .push_i(frm_valid), .push_data_i(frm_entry), .pop_i,
    .data_o(head), .empty_o(rx_empty_o), .count_o(fifo_cnt)
  );

  rxs_timeout #(.LIMIT(TMO_BITS * OS_RATE)) u_tmo (
    .clk_i, .rst_ni, .tick_i(tick),
    .clear_i(frm_start | pop_i | rx_empty_o), .tmo_o(rx_tmo_irq_o)
  );

  assign rd_data_o = head;
  assign rx_irq_o  = (fifo_cnt >= (fifo_en_i ? CW'(DEPTH/2) : CW'(1)));
endmodule

// File: rtl/rxs_chk.sv
module rxs_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [11:0]   rd_data_o,
  input logic          rx_empty_o,
  input logic          rx_irq_o,
  input logic          rx_tmo_irq_o,
  input logic          fifo_en_i,
  input logic          pop_i,
  input logic          push_i,
  input logic [CW-1:0] count_i
);
  p_brk_masks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_empty_o && rd_data_o[11]) |-> (rd_data_o[9:8] == 2'b00));

  p_irq_has_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> !rx_empty_o);

  p_tmo_has_data_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_tmo_irq_o |-> !rx_empty_o);

  p_empty_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_empty_o && !push_i) |=> rx_empty_o);

  p_depth_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(DEPTH));

  p_single_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |-> (count_i <= CW'(1)));

  p_pop_drains_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !rx_empty_o && !push_i) |=> (count_i == $past(count_i) - 1'b1));
endmodule

bind rx_serial_core rxs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_data_o(rd_data_o),
  .rx_empty_o(rx_empty_o), .rx_irq_o(rx_irq_o), .rx_tmo_irq_o(rx_tmo_irq_o),
  .fifo_en_i(fifo_en_i), .pop_i(pop_i), .push_i(frm_valid), .count_i(fifo_cnt)
);

// File: tb/rx_serial_core_tb.sv
module rx_serial_core_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rxd_i = 1'b1;
  logic [15:0] divisor_i = '0;
  logic [1:0]  wlen_i = 2'd3;
  logic        par_en_i = 1'b0;
  logic        par_even_i = 1'b0;
  logic        stop2_i = 1'b0;
  logic        fifo_en_i = 1'b1;
  logic        pop_i = 1'b0;
  logic [11:0] rd_data_o;
  logic        rx_empty_o, rx_irq_o, rx_tmo_irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  rx_serial_core dut_i (.*);

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic int bit_clks();
    return 16 * (int'(divisor_i) + 1);
  endfunction

  task automatic line(input logic v, input int nbits);
    @(negedge clk_i);
    rxd_i = v;
    repeat (nbits * bit_clks() - 1) @(negedge clk_i);
  endtask

  task automatic send(input logic [7:0] ch, input int nbits, input bit pen,
                      input bit pbit, input bit stop_a, input bit stop_b);
    line(1'b0, 1);
    for (int i = 0; i < nbits; i++) line(ch[i], 1);
    if (pen) line(pbit, 1);
    line(stop_a, 1);
    if (stop2_i) line(stop_b, 1);
    line(1'b1, 1);
  endtask

  task automatic send8(input logic [7:0] ch);
    send(ch, 8, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic pop_read(output logic [11:0] v);
    @(negedge clk_i);
    v = rd_data_o;
    pop_i = 1'b1;
    @(negedge clk_i);
    pop_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R13 empty", rx_empty_o, 1);
    chk("R13 irq", rx_irq_o, 0);
    chk("R13 tmo", rx_tmo_irq_o, 0);
    chk("R13 data", rd_data_o, 0);
  endtask

  task automatic t_basic();
    logic [11:0] v;
    send8(8'hA5);
    chk("R9 not empty", rx_empty_o, 0);
    pop_read(v);
    chk("R1 char A5", v, 12'h0A5);
    chk("R9 empty after pop", rx_empty_o, 1);
    pop_read(v);
    chk("R9 pop on empty reads 0", v, 0);
    chk("R9 still empty", rx_empty_o, 1);
  endtask

  task automatic t_wlen();
    logic [11:0] v;
    for (int w = 0; w < 4; w++) begin
      wlen_i = 2'(w);
      send(8'hFF, w + 5, 1'b0, 1'b0, 1'b1, 1'b1);
      pop_read(v);
      chk($sformatf("R2 wlen %0d", w), v, (1 << (w + 5)) - 1);
    end
    wlen_i = 2'd3;
  endtask

  task automatic t_parity();
    logic [11:0] v;
    par_en_i = 1'b1;
    par_even_i = 1'b1;
    send(8'h13, 8, 1'b1, 1'b1, 1'b1, 1'b1);
    pop_read(v); chk("R3 even ok", v, 12'h013);
    send(8'h13, 8, 1'b1, 1'b0, 1'b1, 1'b1);
    pop_read(v); chk("R3 even bad", v, 12'h213);
    par_even_i = 1'b0;
    send(8'h13, 8, 1'b1, 1'b0, 1'b1, 1'b1);
    pop_read(v); chk("R3 odd ok", v, 12'h013);
    send(8'h13, 8, 1'b1, 1'b1, 1'b1, 1'b1);
    pop_read(v); chk("R3 odd bad", v, 12'h213);
    par_en_i = 1'b0;
  endtask

  task automatic t_framing();
    logic [11:0] v;
    send(8'h55, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    pop_read(v); chk("R4 low stop", v, 12'h155);
    stop2_i = 1'b1;
    send(8'h3C, 8, 1'b0, 1'b0, 1'b1, 1'b0);
    pop_read(v); chk("R4 low second stop", v, 12'h13C);
    send(8'h3C, 8, 1'b0, 1'b0, 1'b1, 1'b1);
    pop_read(v); chk("R4 two good stops", v, 12'h03C);
    stop2_i = 1'b0;
  endtask

  task automatic t_break();
    logic [11:0] v;
    par_en_i = 1'b1;
    par_even_i = 1'b0;
    line(1'b0, 14);
    line(1'b1, 2);
    par_en_i = 1'b0;
    pop_read(v); chk("R5 break entry", v, 12'h800);
    chk("R5 single entry", rx_empty_o, 1);
  endtask

  task automatic t_depth();
    logic [11:0] v;
    for (int i = 0; i < 17; i++) begin
      send8(8'(8'h40 + i));
      if (i == 6) chk("R10 irq below half", rx_irq_o, 0);
      if (i == 7) chk("R10 irq at half", rx_irq_o, 1);
    end
    for (int i = 0; i < 16; i++) begin
      pop_read(v);
      chk($sformatf("R6 order %0d", i), v,
          (i == 15) ? (12'h400 | (12'h40 + i)) : (12'h40 + i));
    end
    chk("R7 seventeenth dropped", rx_empty_o, 1);
  endtask

  task automatic t_single();
    logic [11:0] v;
    fifo_en_i = 1'b0;
    send8(8'h21);
    chk("R10 irq single", rx_irq_o, 1);
    send8(8'h22);
    pop_read(v); chk("R8 held first with overrun", v, 12'h421);
    chk("R8 one entry only", rx_empty_o, 1);
    fifo_en_i = 1'b1;
  endtask

  task automatic t_timeout();
    logic [11:0] v;
    send8(8'h77);
    repeat (24 * bit_clks()) @(negedge clk_i);
    chk("R11 no tmo early", rx_tmo_irq_o, 0);
    repeat (10 * bit_clks()) @(negedge clk_i);
    chk("R11 tmo after 32 bits", rx_tmo_irq_o, 1);
    pop_read(v);
    chk("R11 tmo clears", rx_tmo_irq_o, 0);
  endtask

  task automatic t_noise();
    @(negedge clk_i);
    rxd_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (3 * bit_clks()) @(negedge clk_i);
    chk("R12 glitch ignored", rx_empty_o, 1);
  endtask

  task automatic t_rate();
    logic [11:0] v;
    divisor_i = 16'd2;
    send8(8'h5A);
    pop_read(v); chk("R1 divisor 2", v, 12'h05A);
    send8(8'hC3);
    pop_read(v); chk("R1 divisor 2 second", v, 12'h0C3);
    divisor_i = 16'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_wlen();
    t_parity();
    t_framing();
    t_break();
    t_depth();
    t_single();
    t_timeout();
    t_noise();
    t_rate();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule